// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits between a command stream decoder and a set of engine register ports. Each incoming request carries a method number, a 3-bit subchannel and a 32-bit value. The router keeps a small table that records, for each subchannel, whether an engine class has been attached and which class it is. The command stream fills in this table itself, so where a write goes is decided at run time.

Method 0 attaches a class to a subchannel. Methods below 0x100 form a reserved range; they are flagged and dropped. Every higher method is forwarded unchanged to the 2D, 3D or compute engine port, depending on the class attached to its subchannel. Writes that cannot be delivered raise one of four single-cycle error pulses.

The input and every engine port use valid/ready handshakes. Outputs are registered. With no back-pressure, one request is accepted and dispatched every clock.

Top module: `subch_route`

## Requirements
- R1: After a synchronous reset, all subchannels are unattached, no engine port valid is high, no error pulse is high and `in_ready` is high.
- R2: An accepted request with method 0 on an unattached subchannel stores bits 15:0 of its value as that subchannel's class. It raises no error and drives no engine port.
- R3: An accepted method-0 request on an already attached subchannel pulses `err_rebind` in the cycle after acceptance. The existing class is kept.
- R4: An accepted request with a method from 0x001 to 0x0FF pulses `err_special` in the cycle after acceptance and is not forwarded.
- R5: An accepted request with a method of 0x100 or higher on an attached subchannel is forwarded in the cycle after acceptance, with method and value unchanged. Class 0x902D raises `eng2d_valid`, class 0xB197 raises `eng3d_valid` and class 0xB1C0 raises `engcp_valid`. At most one port valid is high at a time.
- R6: A forwarding request (method of 0x100 or higher) on an unattached subchannel pulses `err_unbound` in the cycle after acceptance and is dropped.
- R7: A forwarding request on a subchannel attached to any other class (for example 0xA140 or 0xB0B5) pulses `err_noport` in the cycle after acceptance and is dropped.
- R8: While a port valid is high and that port's ready is low, the port valid, `out_method` and `out_data` hold. After the port accepts the write, its valid falls unless a new write is loaded for it.
- R9: `in_ready` is low exactly when a pending port valid is high and that port's ready is low. Otherwise one request per clock is accepted.
- R10: Each error pulse lasts one cycle per request, and at most one error pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_method | input | 12 | Method number |
| in_subch | input | 3 | Subchannel index |
| in_data | input | 32 | Request value |
| out_method | output | 12 | Method to engines (shared) |
| out_data | output | 32 | Value to engines (shared) |
| eng2d_valid | output | 1 | Write valid, 2D engine |
| eng2d_ready | input | 1 | 2D engine ready |
| eng3d_valid | output | 1 | Write valid, 3D engine |
| eng3d_ready | input | 1 | 3D engine ready |
| engcp_valid | output | 1 | Write valid, compute engine |
| engcp_ready | input | 1 | Compute engine ready |
| err_special | output | 1 | Reserved method pulse |
| err_rebind | output | 1 | Attach to attached subchannel pulse |
| err_unbound | output | 1 | Forward to unattached subchannel pulse |
| err_noport | output | 1 | Forward to class without a port pulse |

## Verification
A directed opening walks one subchannel through its life: a forward while unattached, an attach, a forward, a second attach and a forward that must still reach the first class. Reserved methods at the 0x0FF/0x100 edge and classes without a port are also tried. This separates a first-wins table from a last-wins table and shows where the reserved range ends. Random traffic then mixes attaches, reserved methods and forwards on all eight subchannels. Engine readies are randomly withheld, and periodic resets let the table fill again with new classes. This exercises the holding of stalled writes, the gating of `in_ready` and back-to-back dispatch, all checked against a bench model of the table.

// File: rtl/subch_route_pkg.sv
package subch_route_pkg;
  localparam int NPORT   = 3;
  localparam int CLASS_W = 16;

  localparam logic [CLASS_W-1:0] CLS_2D = 16'h902D;
  localparam logic [CLASS_W-1:0] CLS_3D = 16'hB197;
  localparam logic [CLASS_W-1:0] CLS_CP = 16'hB1C0;

  // port index order: 0 = 2D, 1 = 3D, 2 = compute
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_BIND,
    ACT_REBIND,
    ACT_SPECIAL,
    ACT_FWD,
    ACT_UNBOUND,
    ACT_NOPORT
  } act_e;

  function automatic logic [NPORT-1:0] class_to_port(input logic [CLASS_W-1:0] c);
    logic [NPORT-1:0] sel;
    case (c)
      CLS_2D:  sel = 3'b001;
      CLS_3D:  sel = 3'b010;
      CLS_CP:  sel = 3'b100;
      default: sel = '0;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/subch_class_table.sv
module subch_class_table
  import subch_route_pkg::*;
#(
  parameter int SUBCH_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SUBCH_W-1:0] wr_idx,
  input  logic [CLASS_W-1:0] wr_class,
  input  logic [SUBCH_W-1:0] rd_idx,
  output logic               rd_bound,
  output logic [CLASS_W-1:0] rd_class
);
  localparam int NSUB = 1 << SUBCH_W;

  logic [NSUB-1:0]    bound_q;
  logic [CLASS_W-1:0] cls_q [NSUB];

  always_ff @(posedge clk) begin
    if (rst) bound_q <= '0;
    else if (wr_en) bound_q[wr_idx] <= 1'b1;
  end

  // class storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) cls_q[wr_idx] <= wr_class;
  end

  assign rd_bound = bound_q[rd_idx];
  assign rd_class = cls_q[rd_idx];

  generate
    for (genvar g = 0; g < NSUB; g++) begin : g_chk
      // R3: an attached entry keeps its class until reset
      a_r3_class_kept: assert property (@(posedge clk) disable iff (rst)
        bound_q[g] |=> (cls_q[g] == $past(cls_q[g])));
    end
  endgenerate
endmodule

// File: rtl/subch_decode.sv
module subch_decode
  import subch_route_pkg::*;
#(
  parameter int METH_W      = 12,
  parameter int SPECIAL_END = 256
) (
  input  logic [METH_W-1:0]  method,
  input  logic               bound,
  input  logic [CLASS_W-1:0] cls,
  output act_e               act,
  output logic [NPORT-1:0]   port_sel
);
  localparam logic [METH_W-1:0] SPEC_LIM = METH_W'(SPECIAL_END);

  always_comb begin
    port_sel = class_to_port(cls);
    if (method == '0)            act = bound ? ACT_REBIND : ACT_BIND;
    else if (method < SPEC_LIM)  act = ACT_SPECIAL;
    else if (!bound)             act = ACT_UNBOUND;
    else if (port_sel == '0)     act = ACT_NOPORT;
    else                         act = ACT_FWD;
  end
endmodule

// File: rtl/subch_out_stage.sv
module subch_out_stage
  import subch_route_pkg::*;
#(
  parameter int METH_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NPORT-1:0]  load_sel,
  input  logic [METH_W-1:0] load_method,
  input  logic [DATA_W-1:0] load_data,
  input  logic [NPORT-1:0]  port_ready,
  output logic [NPORT-1:0]  port_valid,
  output logic [METH_W-1:0] out_method,
  output logic [DATA_W-1:0] out_data,
  output logic              stall
);
  assign stall = |(port_valid & ~port_ready);

  always_ff @(posedge clk) begin
    if (rst) port_valid <= '0;
    else if (load) port_valid <= load_sel;
    else if (!stall) port_valid <= '0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_method <= load_method;
      out_data   <= load_data;
    end
  end

  a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(port_valid) && $stable(out_method) && $stable(out_data)));

  a_r5_single_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_valid));
endmodule

// File: rtl/subch_route.sv
module subch_route
  import subch_route_pkg::*;
#(
  parameter int METH_W      = 12,
  parameter int SUBCH_W     = 3,
  parameter int DATA_W      = 32,
  parameter int SPECIAL_END = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [METH_W-1:0]  in_method,
  input  logic [SUBCH_W-1:0] in_subch,
  input  logic [DATA_W-1:0]  in_data,
  output logic [METH_W-1:0]  out_method,
  output logic [DATA_W-1:0]  out_data,
  output logic               eng2d_valid,
  input  logic               eng2d_ready,
  output logic               eng3d_valid,
  input  logic               eng3d_ready,
  output logic               engcp_valid,
  input  logic               engcp_ready,
  output logic               err_special,
  output logic               err_rebind,
  output logic               err_unbound,
  output logic               err_noport
);
  localparam logic [METH_W-1:0] SPEC_LIM = METH_W'(SPECIAL_END);

  logic               fire;
  logic               stall;
  logic               t_bound;
  logic [CLASS_W-1:0] t_class;
  act_e               act;
  logic [NPORT-1:0]   sel;
  logic [NPORT-1:0]   p_ready;
  logic [NPORT-1:0]   p_valid;

  assign p_ready  = {engcp_ready, eng3d_ready, eng2d_ready};
  assign in_ready = !stall;
  assign fire     = in_valid && in_ready;

  subch_class_table #(.SUBCH_W(SUBCH_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fire && act == ACT_BIND),
    .wr_idx   (in_subch),
    .wr_class (in_data[CLASS_W-1:0]),
    .rd_idx   (in_subch),
    .rd_bound (t_bound),
    .rd_class (t_class)
  );

  subch_decode #(.METH_W(METH_W), .SPECIAL_END(SPECIAL_END)) u_dec (
    .method   (in_method),
    .bound    (t_bound),
    .cls      (t_class),
    .act      (act),
    .port_sel (sel)
  );

  subch_out_stage #(.METH_W(METH_W), .DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .load        (fire && act == ACT_FWD),
    .load_sel    (sel),
    .load_method (in_method),
    .load_data   (in_data),
    .port_ready  (p_ready),
    .port_valid  (p_valid),
    .out_method  (out_method),
    .out_data    (out_data),
    .stall       (stall)
  );

  assign eng2d_valid = p_valid[0];
  assign eng3d_valid = p_valid[1];
  assign engcp_valid = p_valid[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_special <= 1'b0;
      err_rebind  <= 1'b0;
      err_unbound <= 1'b0;
      err_noport  <= 1'b0;
    end else begin
      err_special <= fire && act == ACT_SPECIAL;
      err_rebind  <= fire && act == ACT_REBIND;
      err_unbound <= fire && act == ACT_UNBOUND;
      err_noport  <= fire && act == ACT_NOPORT;
    end
  end

  // R10: error pulses never overlap
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_special, err_rebind, err_unbound, err_noport}));

  // R4 and R2: low methods never start a new engine write
  a_r4_low_methods_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    (fire && in_method < SPEC_LIM) |=> ((p_valid & ~$past(p_valid)) == '0));

  // R6: forward to unattached subchannel is dropped
  a_r6_unbound_dropped: assert property (@(posedge clk) disable iff (rst)
    (fire && in_method >= SPEC_LIM && !t_bound) |=> (err_unbound && (p_valid & ~$past(p_valid)) == '0));
endmodule

// File: tb/sim_subch_route.sv
`timescale 1ns/1ps
module sim_subch_route;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_method = '0;
  logic [2:0]  in_subch = '0;
  logic [31:0] in_data = '0;
  logic [11:0] out_method;
  logic [31:0] out_data;
  logic        eng2d_valid, eng3d_valid, engcp_valid;
  logic        eng2d_ready = 1'b1, eng3d_ready = 1'b1, engcp_ready = 1'b1;
  logic        err_special, err_rebind, err_unbound, err_noport;

  always #2.5 clk = ~clk;

  subch_route u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_method(in_method), .in_subch(in_subch), .in_data(in_data),
    .out_method(out_method), .out_data(out_data),
    .eng2d_valid(eng2d_valid), .eng2d_ready(eng2d_ready),
    .eng3d_valid(eng3d_valid), .eng3d_ready(eng3d_ready),
    .engcp_valid(engcp_valid), .engcp_ready(engcp_ready),
    .err_special(err_special), .err_rebind(err_rebind),
    .err_unbound(err_unbound), .err_noport(err_noport)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit primed = 1'b0;

  // bench model
  bit          m_bound [8];
  logic [15:0] m_cls   [8];
  logic [2:0]  e_vld = '0;
  logic [11:0] e_meth = '0;
  logic [31:0] e_data = '0;
  logic [3:0]  e_flags = '0;   // {special, rebind, unbound, noport}

  function automatic logic [2:0] port_of(input logic [15:0] c);
    if (c == 16'h902D) return 3'b001;
    if (c == 16'hB197) return 3'b010;
    if (c == 16'hB1C0) return 3'b100;
    return 3'b000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk("R5 R8 port valids", {29'd0, engcp_valid, eng3d_valid, eng2d_valid}, {29'd0, e_vld});
    if (e_vld != 3'b000) begin
      chk("R5 R8 method", {20'd0, out_method}, {20'd0, e_meth});
      chk("R5 R8 data", out_data, e_data);
    end
    chk("R3 R4 R6 R7 R10 flags",
        {28'd0, err_special, err_rebind, err_unbound, err_noport}, {28'd0, e_flags});
  endtask

  task automatic step(input bit v, input logic [11:0] m, input logic [2:0] s,
                      input logic [31:0] d, input logic [2:0] rdy, input bit rs);
    bit exp_ready;
    bit fire;
    logic [2:0] p;
    @(negedge clk);
    if (primed) compare_outputs();
    rst = rs; in_valid = v; in_method = m; in_subch = s; in_data = d;
    {engcp_ready, eng3d_ready, eng2d_ready} = rdy;
    #1;
    exp_ready = !(|(e_vld & ~rdy));
    if (primed) chk("R9 in_ready", {31'd0, in_ready}, {31'd0, exp_ready});
    fire = v && exp_ready && !rs;
    if (rs) begin
      foreach (m_bound[i]) m_bound[i] = 1'b0;
      e_vld = '0; e_flags = '0;
      primed = 1'b1;
    end else begin
      e_flags = '0;
      p = '0;
      if (fire) begin
        if (m == 12'h000) begin
          if (m_bound[s]) e_flags = 4'b0100;
          else begin m_bound[s] = 1'b1; m_cls[s] = d[15:0]; end
        end else if (m < 12'h100) e_flags = 4'b1000;
        else if (!m_bound[s]) e_flags = 4'b0010;
        else begin
          p = port_of(m_cls[s]);
          if (p == 3'b000) e_flags = 4'b0001;
        end
      end
      if (p != 3'b000) begin
        e_vld = p; e_meth = m; e_data = d;
      end else if (exp_ready) e_vld = '0;
    end
  endtask

  function automatic logic [31:0] pick_class();
    logic [31:0] hi = $urandom & 32'hFFFF_0000;
    case ($urandom % 7)
      0: return hi | 32'h902D;
      1: return hi | 32'hB197;
      2: return hi | 32'hB1C0;
      3: return hi | 32'hA140;
      4: return hi | 32'hB0B5;
      5: return 32'h0000_902D;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    step(0, 0, 0, 0, 3'b111, 1);
    step(0, 0, 0, 0, 3'b111, 1);
    step(0, 0, 0, 0, 3'b111, 0);
    // R1: reset state
    chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R1 no port valid", {29'd0, engcp_valid, eng3d_valid, eng2d_valid}, 32'd0);
    // directed life of subchannel 2
    step(1, 12'h100, 2, 32'h1111, 3'b111, 0);        // R6 unbound
    step(1, 12'h000, 2, 32'hABCD_902D, 3'b111, 0);   // R2 attach 2D
    step(1, 12'h1FF, 2, 32'hDEADBEEF, 3'b111, 0);    // R5 to 2D
    step(1, 12'h000, 2, 32'h0000_B197, 3'b111, 0);   // R3 rebind
    step(1, 12'h100, 2, 32'h5555_AAAA, 3'b111, 0);   // R3 still 2D
    step(1, 12'h0FF, 2, 32'h1, 3'b111, 0);           // R4 top of reserved
    step(1, 12'h001, 5, 32'h2, 3'b111, 0);           // R4 bottom of reserved
    step(1, 12'h000, 3, 32'h0000_B0B5, 3'b111, 0);
    step(1, 12'h300, 3, 32'h3, 3'b111, 0);           // R7 no port
    step(1, 12'h000, 4, 32'h0000_B197, 3'b111, 0);
    step(1, 12'h000, 6, 32'h0000_B1C0, 3'b111, 0);
    step(1, 12'h222, 4, 32'h4444, 3'b000, 0);        // R8 stall on 3D
    step(1, 12'h223, 6, 32'h6666, 3'b101, 0);        // R9 blocked
    step(1, 12'h223, 6, 32'h6666, 3'b101, 0);
    step(1, 12'h224, 6, 32'h7777, 3'b010, 0);        // released, load compute
    step(1, 12'h225, 2, 32'h8888, 3'b111, 0);        // back-to-back
    step(0, 12'h000, 0, 32'h0, 3'b111, 0);
    step(0, 12'h000, 0, 32'h0, 3'b111, 0);
    chk("R1 R8 valid cleared after drain", {29'd0, engcp_valid, eng3d_valid, eng2d_valid}, 32'd0);
    // constrained random
    for (int c = 0; c < 8000; c++) begin
      logic [11:0] m;
      logic [31:0] d;
      int k = $urandom % 100;
      d = $urandom;
      if (k < 20) begin m = 12'h000; d = pick_class(); end
      else if (k < 30) m = 12'(1 + $urandom % 255);
      else if (k < 35) m = ($urandom % 2) ? 12'h0FF : 12'h100;
      else m = 12'(256 + $urandom % 3840);
      step(($urandom % 100) < 80, m, 3'($urandom), d,
           {($urandom % 10) < 7, ($urandom % 10) < 7, ($urandom % 10) < 7},
           (c % 700) == 699);
    end
    step(0, 0, 0, 0, 3'b111, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule